// File: doc/BRIEF.md
# Hash Work Queue and Result Buffer

This block sits behind a byte-oriented register port and manages work for a set of hashing cores. The host streams fixed-size task records into a task address; each complete record enters a task queue that the cores draw from over a valid/ready stream. Cores return fixed-size result records over a second valid/ready stream into a result buffer. The host learns how many results are waiting from a status address and drains them byte by byte from a result address.

A command address accepts 32-bit command words that either restore the whole block to its power-up state or discard every queued task. A control byte pauses the cores, holds the task stream, decides whether completion-without-nonce results are kept, and carries a test-mode bit. Two 32-bit registers publish the starting nonce and the per-core nonce stride to the cores.

The host port has no back-pressure: every byte presented with a valid strobe is taken in that cycle, and reads answer one cycle later. Back-pressure exists only on the two record streams: a task stays offered, with stable data, until the consumer raises ready, and the block lowers its result ready whenever the result buffer is full.

Top module: `wq_hub`

## Requirements
- R1: Bytes written to address 0x30 fill a 48-byte task record in arrival order; after the 48th byte the record joins the task queue one cycle later, with byte i on task_data bits [383-8i:376-8i]. Byte 0 carries the upper half of the 16-bit task ID, byte 1 the lower half, bytes 2-3 are zero, 4-35 the midstate and 36-47 the block tail.
- R2: Tasks leave in write order; task_valid is high while the queue holds a task and control bit 3 (queue pause) is clear, and task_data stays unchanged while task_valid is high and task_ready is low.
- R3: The task queue holds at most 16 records; a record completed while the queue is full is discarded and task_overflow rises and stays high until a full reset.
- R4: An accepted result becomes an 8-byte record: bytes 0-1 task ID with the upper half first, byte 2 core ID, byte 3 bit 7 the no-nonce flag (other bits zero), bytes 4-7 the nonce with its least significant byte first. Reads of address 0x20 return the oldest record's bytes in that order, and reading byte 7 removes the record.
- R5: A read of address 0x20 while the result buffer is empty returns 0xFF and removes nothing.
- R6: Reading address 0x0B returns the number of waiting results in byte 0 and 0x00 in bytes 1-3.
- R7: A result whose no-nonce flag is set is accepted but not stored unless control bit 2 is set.
- R8: Byte 0 written to address 0x06 sets the control byte (bit 4 core pause, bit 3 queue pause, bit 2 keep no-nonce results, bit 1 test mode); it reads back in byte 0 of 0x06, resets to 0x18, and drives core_pause and test_mode.
- R9: At address 0x07 the byte sequence FF FF A5 F5 empties both buffers, clears task_overflow, restores control to 0x18 and zeroes both nonce registers; FB FF FF FF empties only the task queue; any other word has no effect.
- R10: Four bytes written to 0x70 set nonce_base and to 0x71 set nonce_step, least significant byte first.
- R11: res_ready is low exactly when the result buffer holds 8 records; a result offered while res_ready is low is not taken.
- R12: Every read byte is returned on rd_data one cycle after its request, marked by rd_data_valid.
- R13: A start strobe restarts the byte position of a burst at 0; without it the position advances and wraps at the record length (48 for 0x30, 8 for 0x20, 4 elsewhere), so one burst may carry several records.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Host write byte strobe |
| wr_start | input | 1 | First byte of a write burst |
| wr_addr | input | 8 | Write register address |
| wr_data | input | 8 | Write byte |
| rd_valid | input | 1 | Host read byte request |
| rd_start | input | 1 | First byte of a read burst |
| rd_addr | input | 8 | Read register address |
| rd_data | output | 8 | Read byte, one cycle after request |
| rd_data_valid | output | 1 | rd_data holds a fresh byte |
| task_valid | output | 1 | A task is offered to the cores |
| task_ready | input | 1 | Cores take the offered task |
| task_data | output | 384 | Offered task record |
| res_valid | input | 1 | A core offers a result |
| res_ready | output | 1 | Result buffer can take a result |
| res_task_id | input | 16 | Result task ID |
| res_core_id | input | 8 | Result core ID |
| res_no_nonce | input | 1 | Result reports completion without nonce |
| res_nonce | input | 32 | Result nonce |
| core_pause | output | 1 | Control bit 4 |
| test_mode | output | 1 | Control bit 1 |
| task_overflow | output | 1 | Sticky task-drop flag |
| nonce_base | output | 32 | Starting nonce |
| nonce_step | output | 32 | Per-core nonce stride |

## Verification
A corrupted queue pointer or count shows at the ports within one cycle as a wrong task_valid or a changed task_data, and as a wrong status byte on the next status read. A lost or duplicated result record shows as a wrong byte on the next result read, and a wrong byte position after a burst restart shows on the very next returned byte. Because the bench model recomputes every output each clock, any divergence in control, nonce or overflow state is reported in the cycle it first becomes visible.

// File: rtl/wq_pkg.sv
`timescale 1ns/1ps
package wq_pkg;
  localparam logic [7:0] ADDR_TASK  = 8'h30;
  localparam logic [7:0] ADDR_RES   = 8'h20;
  localparam logic [7:0] ADDR_STAT  = 8'h0B;
  localparam logic [7:0] ADDR_CMD   = 8'h07;
  localparam logic [7:0] ADDR_CTRL  = 8'h06;
  localparam logic [7:0] ADDR_NBASE = 8'h70;
  localparam logic [7:0] ADDR_NSTEP = 8'h71;

  localparam int TASK_BYTES = 48;
  localparam int RES_BYTES  = 8;
  localparam int WORD_BYTES = 4;

  localparam logic [31:0] CMD_FULL_RESET = 32'hFFFF_A5F5;
  localparam logic [31:0] CMD_FLUSH      = 32'hFBFF_FFFF;

  localparam logic [7:0] CTRL_RESET = 8'h18;
  localparam int CB_CORE_PAUSE  = 4;
  localparam int CB_QUEUE_PAUSE = 3;
  localparam int CB_KEEP_EMPTY  = 2;
  localparam int CB_TEST        = 1;

  function automatic logic [63:0] pack_result(input logic [15:0] id, input logic [7:0] core,
                                              input logic no_nonce, input logic [31:0] nonce);
    return {id, core, no_nonce, 7'b0, nonce[7:0], nonce[15:8], nonce[23:16], nonce[31:24]};
  endfunction
endpackage

// File: rtl/wq_fifo.sv
`timescale 1ns/1ps
module wq_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_push) wp <= step(wp);
      if (do_pop)  rp <= step(rp);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  // R3 and R11: callers never present a record to a full buffer
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  // R3: occupancy never exceeds the depth
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n) count <= CW'(DEPTH));
  // R9: a clear leaves the buffer empty
  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n) clr |=> empty);
endmodule

// File: rtl/wq_wr_decode.sv
`timescale 1ns/1ps
module wq_wr_decode
  import wq_pkg::*;
#(
  parameter int REC_BYTES = TASK_BYTES
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_valid,
  input  logic                         wr_start,
  input  logic [7:0]                   wr_addr,
  input  logic [7:0]                   wr_data,
  output logic                         rec_push,
  output logic [8*REC_BYTES-1:0]       rec_data,
  output logic                         cmd_reset,
  output logic                         cmd_flush,
  output logic [$clog2(REC_BYTES)-1:0] byte_idx
);
  localparam int IW = $clog2(REC_BYTES);

  logic [IW-1:0] pos;
  logic [IW-1:0] last;
  logic [23:0]   cmd_hi;
  logic [31:0]   cmd_word;
  logic          is_task, is_cmd;

  assign is_task  = wr_valid && (wr_addr == ADDR_TASK);
  assign is_cmd   = wr_valid && (wr_addr == ADDR_CMD);
  assign byte_idx = wr_start ? '0 : pos;
  assign last     = (wr_addr == ADDR_TASK) ? IW'(REC_BYTES-1) : IW'(WORD_BYTES-1);
  assign cmd_word = {cmd_hi, wr_data};
  assign cmd_reset = is_cmd && (byte_idx == IW'(WORD_BYTES-1)) && (cmd_word == CMD_FULL_RESET);
  assign cmd_flush = is_cmd && (byte_idx == IW'(WORD_BYTES-1)) && (cmd_word == CMD_FLUSH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos      <= '0;
      cmd_hi   <= '0;
      rec_push <= 1'b0;
      rec_data <= '0;
    end else begin
      rec_push <= is_task && (byte_idx == IW'(REC_BYTES-1));
      if (wr_valid) pos <= (byte_idx == last) ? '0 : byte_idx + 1'b1;
      if (is_cmd)   cmd_hi <= {cmd_hi[15:0], wr_data};
      if (is_task)  rec_data[(REC_BYTES-1-int'(byte_idx))*8 +: 8] <= wr_data;
    end
  end

  // R1: a record is handed on only in the cycle after its final byte
  a_r1_push_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    rec_push |-> $past(is_task && byte_idx == IW'(REC_BYTES-1)));
endmodule

// File: rtl/wq_hub.sv
`timescale 1ns/1ps
module wq_hub
  import wq_pkg::*;
#(
  parameter int TASK_DEPTH = 16,
  parameter int RES_DEPTH  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_valid,
  input  logic                      wr_start,
  input  logic [7:0]                wr_addr,
  input  logic [7:0]                wr_data,
  input  logic                      rd_valid,
  input  logic                      rd_start,
  input  logic [7:0]                rd_addr,
  output logic [7:0]                rd_data,
  output logic                      rd_data_valid,
  output logic                      task_valid,
  input  logic                      task_ready,
  output logic [8*TASK_BYTES-1:0]   task_data,
  input  logic                      res_valid,
  output logic                      res_ready,
  input  logic [15:0]               res_task_id,
  input  logic [7:0]                res_core_id,
  input  logic                      res_no_nonce,
  input  logic [31:0]               res_nonce,
  output logic                      core_pause,
  output logic                      test_mode,
  output logic                      task_overflow,
  output logic [31:0]               nonce_base,
  output logic [31:0]               nonce_step
);
  localparam int TW  = 8*TASK_BYTES;
  localparam int IW  = $clog2(TASK_BYTES);
  localparam int RIW = $clog2(RES_BYTES);
  localparam int TCW = $clog2(TASK_DEPTH+1);
  localparam int RCW = $clog2(RES_DEPTH+1);

  logic          rec_push, cmd_reset, cmd_flush;
  logic [TW-1:0] rec_data;
  logic [IW-1:0] widx;
  logic [7:0]    ctrl;

  logic [TCW-1:0] t_count;
  logic           t_full, t_empty, t_pop;
  logic [RCW-1:0] r_count;
  logic           r_full, r_empty, r_push, r_pop, r_take;
  logic [63:0]    r_dout;

  logic [RIW-1:0] rpos, ridx, rlast;
  logic [1:0]     widx_lo;
  logic [7:0]     rd_byte;

  wq_wr_decode #(.REC_BYTES(TASK_BYTES)) u_dec (
    .clk, .rst_n, .wr_valid, .wr_start, .wr_addr, .wr_data,
    .rec_push, .rec_data, .cmd_reset, .cmd_flush, .byte_idx(widx)
  );

  // task side
  assign task_valid = !t_empty && !ctrl[CB_QUEUE_PAUSE];
  assign t_pop      = task_valid && task_ready;

  wq_fifo #(.W(TW), .DEPTH(TASK_DEPTH)) u_tq (
    .clk, .rst_n, .clr(cmd_reset || cmd_flush),
    .push(rec_push && !t_full), .din(rec_data), .pop(t_pop),
    .dout(task_data), .count(t_count), .full(t_full), .empty(t_empty)
  );

  // result side
  assign res_ready = !r_full;
  assign r_take    = res_valid && res_ready;
  assign r_push    = r_take && !(res_no_nonce && !ctrl[CB_KEEP_EMPTY]);

  wq_fifo #(.W(64), .DEPTH(RES_DEPTH)) u_rq (
    .clk, .rst_n, .clr(cmd_reset),
    .push(r_push), .din(pack_result(res_task_id, res_core_id, res_no_nonce, res_nonce)),
    .pop(r_pop), .dout(r_dout), .count(r_count), .full(r_full), .empty(r_empty)
  );

  // control and nonce registers
  assign core_pause = ctrl[CB_CORE_PAUSE];
  assign test_mode  = ctrl[CB_TEST];
  assign widx_lo    = widx[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl          <= CTRL_RESET;
      task_overflow <= 1'b0;
      nonce_base    <= '0;
      nonce_step    <= '0;
    end else if (cmd_reset) begin
      ctrl          <= CTRL_RESET;
      task_overflow <= 1'b0;
      nonce_base    <= '0;
      nonce_step    <= '0;
    end else begin
      if (rec_push && t_full) task_overflow <= 1'b1;
      if (wr_valid && wr_addr == ADDR_CTRL && widx == '0) ctrl <= wr_data;
      if (wr_valid && wr_addr == ADDR_NBASE) nonce_base[int'(widx_lo)*8 +: 8] <= wr_data;
      if (wr_valid && wr_addr == ADDR_NSTEP) nonce_step[int'(widx_lo)*8 +: 8] <= wr_data;
    end
  end

  // read port
  assign ridx  = rd_start ? '0 : rpos;
  assign rlast = (rd_addr == ADDR_RES) ? RIW'(RES_BYTES-1) : RIW'(WORD_BYTES-1);
  assign r_pop = rd_valid && (rd_addr == ADDR_RES) && (ridx == RIW'(RES_BYTES-1)) && !r_empty;

  always_comb begin
    rd_byte = 8'h00;
    case (rd_addr)
      ADDR_RES:  rd_byte = r_empty ? 8'hFF : r_dout[(RES_BYTES-1-int'(ridx))*8 +: 8];
      ADDR_STAT: rd_byte = (ridx == '0) ? 8'(r_count) : 8'h00;
      ADDR_CTRL: rd_byte = (ridx == '0) ? ctrl : 8'h00;
      default:   rd_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpos          <= '0;
      rd_data       <= '0;
      rd_data_valid <= 1'b0;
    end else begin
      rd_data_valid <= rd_valid;
      if (rd_valid) begin
        rd_data <= rd_byte;
        rpos    <= (ridx == rlast) ? '0 : ridx + 1'b1;
      end
    end
  end

  // R2: an offered, unaccepted task keeps its data
  a_r2_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (task_valid && !task_ready && !cmd_reset && !cmd_flush) |=> $stable(task_data));
  // R3: the overflow flag only falls through a full reset
  a_r3_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(task_overflow) |-> $past(cmd_reset));
  // R3: the task queue stays within its depth
  a_r3_task_bound: assert property (@(posedge clk) disable iff (!rst_n) t_count <= TCW'(TASK_DEPTH));
  // R7: a suppressed completion leaves the result count unchanged
  a_r7_suppress: assert property (@(posedge clk) disable iff (!rst_n)
    (r_take && res_no_nonce && !ctrl[CB_KEEP_EMPTY] && !r_pop && !cmd_reset) |=> $stable(r_count));
  // R8: a full reset restores the control byte
  a_r8_ctrl_restore: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_reset) |-> (ctrl == CTRL_RESET));
endmodule

// File: tb/wq_hub_bench.sv
`timescale 1ns/1ps
module wq_hub_bench;
  localparam int TD = 16;
  localparam int RD = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 0, wr_start = 0, rd_valid = 0, rd_start = 0;
  logic [7:0] wr_addr = 0, wr_data = 0, rd_addr = 0;
  logic [7:0] rd_data;
  logic rd_data_valid, task_valid, res_ready, core_pause, test_mode, task_overflow;
  logic task_ready = 0, res_valid = 0, res_no_nonce = 0;
  logic [383:0] task_data;
  logic [15:0] res_task_id = 0;
  logic [7:0] res_core_id = 0;
  logic [31:0] res_nonce = 0, nonce_base, nonce_step;

  always #10 clk = ~clk;

  wq_hub u_wq_hub (.*);

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [383:0] act, input logic [383:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [383:0] tq[$];
  logic [63:0]  rq[$];
  logic [7:0]   m_ctrl, m_rd;
  logic         m_ovf, m_rdv, m_pend, m_init = 0;
  logic [31:0]  m_nb, m_ns;
  logic [383:0] m_buf;
  logic [23:0]  m_cmd;
  int           m_widx, m_ridx;

  always @(posedge clk) begin
    if (!rst_n) begin
      tq.delete(); rq.delete();
      m_ctrl = 8'h18; m_ovf = 0; m_nb = 0; m_ns = 0; m_pend = 0; m_buf = '0; m_cmd = '0;
      m_widx = 0; m_ridx = 0; m_rdv = 0; m_rd = 0; m_init = 1;
    end else begin
      int tsz, rsz, ri, wi, rlast, wlast;
      bit tv, rr, rpop, pend, drst, dfl;
      logic [383:0] prec;
      logic [7:0] cold;
      tsz = tq.size(); rsz = rq.size(); cold = m_ctrl;
      tv = (tsz > 0) && !m_ctrl[3]; rr = rsz < RD; rpop = 0; drst = 0; dfl = 0;
      m_rdv = rd_valid;
      if (rd_valid) begin
        ri = rd_start ? 0 : m_ridx;
        rlast = (rd_addr == 8'h20) ? 7 : 3;
        case (rd_addr)
          8'h20: if (rsz > 0) begin m_rd = rq[0][(7-ri)*8 +: 8]; rpop = (ri == 7); end
                 else m_rd = 8'hFF;
          8'h0B: m_rd = (ri == 0) ? 8'(rsz) : 8'h00;
          8'h06: m_rd = (ri == 0) ? m_ctrl : 8'h00;
          default: m_rd = 8'h00;
        endcase
        m_ridx = (ri == rlast) ? 0 : ri + 1;
      end
      pend = m_pend; prec = m_buf; m_pend = 0;
      if (wr_valid) begin
        wi = wr_start ? 0 : m_widx;
        wlast = (wr_addr == 8'h30) ? 47 : 3;
        case (wr_addr)
          8'h30: begin m_buf[(47-wi)*8 +: 8] = wr_data; if (wi == 47) m_pend = 1; end
          8'h07: begin
            if (wi == 3 && {m_cmd, wr_data} == 32'hFFFFA5F5) drst = 1;
            if (wi == 3 && {m_cmd, wr_data} == 32'hFBFFFFFF) dfl = 1;
            m_cmd = {m_cmd[15:0], wr_data};
          end
          8'h06: if (wi == 0) m_ctrl = wr_data;
          8'h70: m_nb[wi*8 +: 8] = wr_data;
          8'h71: m_ns[wi*8 +: 8] = wr_data;
          default: ;
        endcase
        m_widx = (wi == wlast) ? 0 : wi + 1;
      end
      if (tv && task_ready) void'(tq.pop_front());
      if (pend) begin
        if (tsz >= TD) m_ovf = 1; else tq.push_back(prec);
      end
      if (rpop) void'(rq.pop_front());
      if (res_valid && rr && !(res_no_nonce && !cold[2]))
        rq.push_back({res_task_id, res_core_id, res_no_nonce, 7'b0,
                      res_nonce[7:0], res_nonce[15:8], res_nonce[23:16], res_nonce[31:24]});
      if (dfl) tq.delete();
      if (drst) begin
        tq.delete(); rq.delete(); m_ctrl = 8'h18; m_ovf = 0; m_nb = 0; m_ns = 0;
      end
    end
  end

  // per-clock comparison
  always @(negedge clk) begin
    if (rst_n && m_init) begin
      bit etv;
      etv = (tq.size() > 0) && !m_ctrl[3];
      chk(task_valid === etv, "R2 task_valid", task_valid, etv);
      if (etv) chk(task_data === tq[0], "R1 task_data", task_data, tq[0]);
      chk(res_ready === (rq.size() < RD), "R11 res_ready", res_ready, rq.size() < RD);
      chk(task_overflow === m_ovf, "R3 overflow", task_overflow, m_ovf);
      chk(core_pause === m_ctrl[4], "R8 core_pause", core_pause, m_ctrl[4]);
      chk(test_mode === m_ctrl[1], "R8 test_mode", test_mode, m_ctrl[1]);
      chk(nonce_base === m_nb, "R10 nonce_base", nonce_base, m_nb);
      chk(nonce_step === m_ns, "R10 nonce_step", nonce_step, m_ns);
      chk(rd_data_valid === m_rdv, "R12 rd_data_valid", rd_data_valid, m_rdv);
      if (m_rdv) chk(rd_data === m_rd, "R12 rd_data", rd_data, m_rd);
    end
  end

  // ---------------- stimulus helpers ----------------
  logic [7:0] wbuf [0:95];
  logic [7:0] got  [0:7];

  task automatic wr_burst(input logic [7:0] a, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_valid = 1; wr_start = (i == 0); wr_addr = a; wr_data = wbuf[i];
    end
    @(negedge clk);
    wr_valid = 0; wr_start = 0;
  endtask

  task automatic wr_word(input logic [7:0] a, input logic [31:0] w);
    wbuf[0] = w[31:24]; wbuf[1] = w[23:16]; wbuf[2] = w[15:8]; wbuf[3] = w[7:0];
    wr_burst(a, 4);
  endtask

  task automatic rd_burst(input logic [7:0] a, input int n);
    for (int i = 0; i <= n; i++) begin
      @(negedge clk);
      if (i > 0) begin
        got[i-1] = rd_data;
        chk(rd_data_valid === 1'b1, "R12 latency", rd_data_valid, 1);
      end
      if (i < n) begin rd_valid = 1; rd_start = (i == 0); rd_addr = a; end
      else begin rd_valid = 0; rd_start = 0; end
    end
  endtask

  function automatic logic [7:0] tbyte(input int t, input int i);
    if (i == 0) return 8'(t >> 8);
    if (i == 1) return 8'(t);
    if (i < 4) return 8'h00;
    return 8'((t * 29 + i * 13 + 7) & 255);
  endfunction

  task automatic fill_task(input int t, input int off);
    for (int i = 0; i < 48; i++) wbuf[off + i] = tbyte(t, i);
  endtask

  task automatic push_res(input logic [15:0] id, input logic [7:0] core, input logic nn, input logic [31:0] nc);
    @(negedge clk);
    res_valid = 1; res_task_id = id; res_core_id = core; res_no_nonce = nn; res_nonce = nc;
    @(negedge clk);
    res_valid = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin : main
    int cnt;
    logic [383:0] first;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk(core_pause === 1'b1, "R8 reset core_pause", core_pause, 1);
    chk(task_valid === 1'b0, "R2 reset task_valid", task_valid, 0);
    chk(task_overflow === 1'b0, "R3 reset overflow", task_overflow, 0);
    rd_burst(8'h06, 1);
    chk(got[0] === 8'h18, "R8 reset ctrl", got[0], 8'h18);
    rd_burst(8'h0B, 4);
    chk(got[0] === 8'h00 && got[3] === 8'h00, "R6 empty status", {got[0], got[3]}, 0);

    wr_word(8'h06, 32'h0600_0000);
    chk(core_pause === 1'b0 && test_mode === 1'b1, "R8 ctrl write", {core_pause, test_mode}, 2'b01);
    wr_word(8'h06, 32'h0400_0000);

    // one task, layout
    fill_task(16'h1234, 0);
    wr_burst(8'h30, 48);
    @(negedge clk);
    chk(task_valid === 1'b1, "R1 task queued", task_valid, 1);
    for (int i = 0; i < 48; i++)
      chk(task_data[383-8*i -: 8] === tbyte(16'h1234, i), "R1 byte order", task_data[383-8*i -: 8], tbyte(16'h1234, i));
    first = task_data;
    wr_word(8'h06, 32'h0C00_0000);
    chk(task_valid === 1'b0, "R2 queue pause", task_valid, 0);
    wr_word(8'h06, 32'h0400_0000);

    // fill beyond depth
    for (int t = 1; t < 17; t++) begin fill_task(t + 100, 0); wr_burst(8'h30, 48); end
    @(negedge clk);
    chk(task_overflow === 1'b1, "R3 overflow set", task_overflow, 1);
    task_ready = 1; cnt = 0;
    chk(task_data === first, "R2 order head", task_data, first);
    for (int k = 0; k < 20; k++) begin @(negedge clk); end
    task_ready = 0;
    chk(task_valid === 1'b0, "R3 drained", task_valid, 0);
    chk(task_overflow === 1'b1, "R3 overflow sticky", task_overflow, 1);

    // two tasks in one burst
    fill_task(16'h0A0B, 0); fill_task(16'h0C0D, 48);
    wr_burst(8'h30, 96);
    @(negedge clk);
    task_ready = 1;
    for (int k = 0; k < 4; k++) begin
      if (task_valid) cnt++;
      @(negedge clk);
    end
    task_ready = 0;
    chk(cnt == 2, "R13 two records per burst", cnt, 2);

    // results
    push_res(16'hABCD, 8'h03, 1'b0, 32'h1234_5678);
    rd_burst(8'h0B, 1);
    chk(got[0] === 8'h01, "R6 count one", got[0], 1);
    rd_burst(8'h20, 8);
    chk({got[0], got[1], got[2], got[3], got[4], got[5], got[6], got[7]} === 64'hABCD_0300_7856_3412,
        "R4 record bytes", {got[0], got[1], got[2], got[3], got[4], got[5], got[6], got[7]}, 64'hABCD_0300_7856_3412);
    rd_burst(8'h0B, 1);
    chk(got[0] === 8'h00, "R4 popped", got[0], 0);
    rd_burst(8'h20, 1);
    chk(got[0] === 8'hFF, "R5 empty read", got[0], 8'hFF);

    // no-nonce handling
    wr_word(8'h06, 32'h0000_0000);
    push_res(16'h0001, 8'h01, 1'b1, 32'h0);
    rd_burst(8'h0B, 1);
    chk(got[0] === 8'h00, "R7 suppressed", got[0], 0);
    wr_word(8'h06, 32'h0400_0000);
    push_res(16'h0102, 8'h05, 1'b1, 32'h0);
    rd_burst(8'h20, 8);
    chk(got[2] === 8'h05 && got[3] === 8'h80, "R7 kept flag", {got[2], got[3]}, 16'h0580);

    // back-pressure
    for (int k = 0; k < 9; k++) push_res(16'(k + 16'h0200), 8'(k), 1'b0, 32'(k));
    chk(res_ready === 1'b0, "R11 full", res_ready, 0);
    rd_burst(8'h0B, 1);
    chk(got[0] === 8'h08, "R11 ninth dropped", got[0], 8);
    rd_burst(8'h20, 3);
    rd_burst(8'h20, 8);
    chk(got[0] === 8'h02 && got[1] === 8'h00 && got[7] === 8'h00, "R13 restart", {got[0], got[1]}, 16'h0200);
    rd_burst(8'h0B, 1);
    chk(got[0] === 8'h07, "R13 one pop", got[0], 7);

    // flush and unknown command
    fill_task(16'h0777, 0); wr_burst(8'h30, 48);
    wr_word(8'h07, 32'h1234_5678);
    chk(task_valid === 1'b1, "R9 unknown word ignored", task_valid, 1);
    wr_word(8'h07, 32'hFBFF_FFFF);
    chk(task_valid === 1'b0, "R9 flush", task_valid, 0);
    rd_burst(8'h0B, 1);
    chk(got[0] === 8'h07, "R9 flush keeps results", got[0], 7);

    // nonce registers
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    wr_burst(8'h70, 4);
    chk(nonce_base === 32'h4433_2211, "R10 base", nonce_base, 32'h4433_2211);
    wr_word(8'h71, 32'h0F00_00F0);
    chk(nonce_step === 32'hF000_000F, "R10 step", nonce_step, 32'hF000_000F);

    // full reset
    fill_task(16'h0888, 0); wr_burst(8'h30, 48);
    wr_word(8'h07, 32'hFFFF_A5F5);
    chk(task_valid === 1'b0 && task_overflow === 1'b0, "R9 full reset queue", {task_valid, task_overflow}, 0);
    chk(core_pause === 1'b1 && nonce_base === 32'h0, "R9 full reset regs", {core_pause, nonce_base}, 33'h1_0000_0000);
    rd_burst(8'h0B, 1);
    chk(got[0] === 8'h00, "R9 results cleared", got[0], 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule